// File: doc/BRIEF.md
# Crosspoint Routing Controller

This block holds the routing state for a matrix of 16 outputs by 16 inputs. Each output is given a 5-bit routing word: a 4-bit input index plus an enable bit. An output whose enable is clear is disabled and connects to no input. The block produces, for every output, an input select and an enable that drive the analog switch array.

Routing words are staged in a holding rank without disturbing the live routing. A host can fill the holding rank word by word through a parallel port (output address plus word), or all at once through an 80-bit serial shift chain. The serial output passes on the bits pushed out of the far end, so several controllers can be chained on one data line. A single update strobe copies the whole holding rank into the active rank in one clock edge, so all outputs switch together. The reset clears both ranks, which disables every output.

Top module: `xpt_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, both ranks are cleared. After reset `en_bus` and `sel_bus` are all zero, and an update issued before any loading keeps every output disabled.
- R2: When `par_wr` is high and `ser_load_en` is low at an edge, `par_data` is written into the holding word of output `par_addr`. The word reaches the outputs only at a later update.
- R3: When `update` is high at an edge, every output takes its holding word on that same edge. Enable `en_bus[k]` = word bit 4 and `sel_bus[4k+3:4k]` = word bits 3:0.
- R4: `en_bus` and `sel_bus` do not change at any edge without `update` or reset, whatever parallel writes or serial shifts take place.
- R5: A word with bit 4 clear leaves its output disabled (`en_bus[k]`=0). Its index bits are still copied to `sel_bus`.
- R6: When `ser_load_en` is high at an edge, the chain shifts by one bit and takes in `ser_in`. After 80 shifts, the stream sent in time order is: output 0's word first, output 15's word last, each word with the most significant bit first.
- R7: Sampled before each shift edge, `ser_out` gives the bit that is leaving the chain. During 80 shifts it gives the previous holding contents in the same stream order as R6, so a chained device receives them.
- R8: When `ser_load_en` and `par_wr` are both high at an edge, only the shift takes place and the parallel write is ignored.
- R9: When `update` and `par_wr` fall on the same edge, the active rank takes the holding word as it was before the write. The written word waits in the holding rank for the next update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset, disables all outputs |
| ser_load_en | input | 1 | Shift the serial chain by one bit this cycle |
| ser_in | input | 1 | Serial data into the chain |
| ser_out | output | 1 | Serial data out of the chain, for chaining |
| par_wr | input | 1 | Parallel write strobe |
| par_addr | input | 4 | Output whose holding word is written |
| par_data | input | 5 | Routing word: bit 4 enable, bits 3:0 input index |
| update | input | 1 | Copy the holding rank into the active rank |
| sel_bus | output | 64 | Active input index per output, 4 bits each |
| en_bus | output | 16 | Active enable per output |

## Verification
The global update and a holding-rank load can land on the same edge. The bench provokes this by raising `update` together with `par_wr` in one cycle. The scoreboard snapshot taken before the write is the one the outputs must show, and the written word must appear only at the following update. A parallel strobe is also raised in the middle of a serial load, and the result after the load is judged against a model in which that strobe had no effect.

// File: rtl/xpt_pkg.sv
// Shared definitions for the crosspoint routing controller.
// Assumes: holding-rank operations are mutually exclusive per cycle.
package xpt_pkg;

    // Operation applied to the holding rank in one cycle
    typedef enum logic [1:0] {
        HOLD_IDLE  = 2'd0,
        HOLD_SHIFT = 2'd1,
        HOLD_WRITE = 2'd2
    } hold_op_e;

endpackage

// File: rtl/xpt_hold_rank.sv
// Holding (first) rank: one word per output, kept as a single serial chain.
// Chain bit k*WORD_W+j holds bit (WORD_W-1-j) of output k's word, so a stream
// sent output 0 first, MSB first, lands in place after N_OUT*WORD_W shifts.
// Assumes: serial shift takes precedence over a parallel write.
module xpt_hold_rank
    import xpt_pkg::*;
#(
    parameter int N_OUT = 16,
    parameter int SEL_W = 4,
    localparam int WORD_W  = SEL_W + 1,
    localparam int CHAIN_W = N_OUT * WORD_W,
    localparam int ADDR_W  = (N_OUT > 1) ? $clog2(N_OUT) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ser_load_en,
    input  logic               ser_in,
    input  logic               par_wr,
    input  logic [ADDR_W-1:0]  par_addr,
    input  logic [WORD_W-1:0]  par_data,
    output logic               ser_out,
    output logic [CHAIN_W-1:0] hold_words
);

    logic [CHAIN_W-1:0] chain_q;
    hold_op_e           op;

    // Pick the single operation for this cycle (shift wins over write)
    always_comb begin
        if (ser_load_en)  op = HOLD_SHIFT;
        else if (par_wr)  op = HOLD_WRITE;
        else              op = HOLD_IDLE;
    end

    // Update the chain: clear, shift toward output 0, or write one word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            case (op)
                HOLD_SHIFT: chain_q <= {ser_in, chain_q[CHAIN_W-1:1]};
                HOLD_WRITE: begin
                    for (int j = 0; j < WORD_W; j++) begin
                        chain_q[int'(par_addr) * WORD_W + j] <= par_data[WORD_W-1-j];
                    end
                end
                default:    chain_q <= chain_q;
            endcase
        end
    end

    assign ser_out = chain_q[0];

    // Present the chain as natural-order words (bit WORD_W-1 is enable)
    for (genvar k = 0; k < N_OUT; k++) begin : g_word
        for (genvar j = 0; j < WORD_W; j++) begin : g_bit
            assign hold_words[k*WORD_W + WORD_W-1-j] = chain_q[k*WORD_W + j];
        end
    end

    AST_HOLD_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!ser_load_en && !par_wr) |=> $stable(hold_words)); // R2

    AST_PAR_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (par_wr && !ser_load_en) |=>
        (hold_words[int'($past(par_addr)) * WORD_W +: WORD_W] == $past(par_data))); // R2

endmodule

// File: rtl/xpt_active_rank.sv
// Active (second) rank: per-output select and enable registers that load the
// whole holding rank on the update strobe and clear on reset.
// Assumes: hold_words is in natural order, enable in the top bit of each word.
module xpt_active_rank #(
    parameter int N_OUT = 16,
    parameter int SEL_W = 4,
    localparam int WORD_W  = SEL_W + 1,
    localparam int CHAIN_W = N_OUT * WORD_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    update,
    input  logic [CHAIN_W-1:0]      hold_words,
    output logic [N_OUT*SEL_W-1:0]  sel_bus,
    output logic [N_OUT-1:0]        en_bus
);

    for (genvar k = 0; k < N_OUT; k++) begin : g_out
        // Load output k's select and enable on update, clear on reset
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                en_bus[k]                  <= 1'b0;
                sel_bus[k*SEL_W +: SEL_W]  <= '0;
            end else if (update) begin
                en_bus[k]                  <= hold_words[k*WORD_W + SEL_W];
                sel_bus[k*SEL_W +: SEL_W]  <= hold_words[k*WORD_W +: SEL_W];
            end
        end
    end

    AST_RESET_DISABLES: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (en_bus == '0)); // R1

    AST_ACTIVE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !update |=> ($stable(en_bus) && $stable(sel_bus))); // R4

endmodule

// File: rtl/xpt_ctrl.sv
// Crosspoint routing controller top: holding rank loaded serially or in
// parallel, active rank updated from it by one global strobe.
// Assumes: synchronous active-low reset; all inputs synchronous to clk.
module xpt_ctrl #(
    parameter int N_OUT = 16,
    parameter int N_IN  = 16,
    localparam int SEL_W   = (N_IN > 1) ? $clog2(N_IN) : 1,
    localparam int WORD_W  = SEL_W + 1,
    localparam int CHAIN_W = N_OUT * WORD_W,
    localparam int ADDR_W  = (N_OUT > 1) ? $clog2(N_OUT) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    ser_load_en,
    input  logic                    ser_in,
    output logic                    ser_out,
    input  logic                    par_wr,
    input  logic [ADDR_W-1:0]       par_addr,
    input  logic [WORD_W-1:0]       par_data,
    input  logic                    update,
    output logic [N_OUT*SEL_W-1:0]  sel_bus,
    output logic [N_OUT-1:0]        en_bus
);

    logic [CHAIN_W-1:0] hold_words;
    logic [CHAIN_W-1:0] act_words;

    xpt_hold_rank #(.N_OUT(N_OUT), .SEL_W(SEL_W)) u_hold (
        .clk         (clk),
        .rst_n       (rst_n),
        .ser_load_en (ser_load_en),
        .ser_in      (ser_in),
        .par_wr      (par_wr),
        .par_addr    (par_addr),
        .par_data    (par_data),
        .ser_out     (ser_out),
        .hold_words  (hold_words)
    );

    xpt_active_rank #(.N_OUT(N_OUT), .SEL_W(SEL_W)) u_active (
        .clk        (clk),
        .rst_n      (rst_n),
        .update     (update),
        .hold_words (hold_words),
        .sel_bus    (sel_bus),
        .en_bus     (en_bus)
    );

    // Regroup the active buses as words for the transfer check
    for (genvar k = 0; k < N_OUT; k++) begin : g_act
        assign act_words[k*WORD_W +: WORD_W] = {en_bus[k], sel_bus[k*SEL_W +: SEL_W]};
    end

    AST_UPDATE_COPIES_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        update |=> (act_words == $past(hold_words))); // R3

endmodule

// File: tb/xpt_ctrl_tb.sv
module xpt_ctrl_tb;

    localparam int N  = 16;
    localparam int W  = 5;
    localparam int CW = N * W;

    typedef struct {
        logic [N-1:0]   en;
        logic [N*4-1:0] sel;
    } snap_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ser_load_en = 1'b0;
    logic          ser_in = 1'b0;
    logic          ser_out;
    logic          par_wr = 1'b0;
    logic [3:0]    par_addr = '0;
    logic [W-1:0]  par_data = '0;
    logic          update = 1'b0;
    logic [N*4-1:0] sel_bus;
    logic [N-1:0]  en_bus;

    int    n_checks = 0;
    int    n_fail   = 0;
    bit    done     = 0;
    logic [CW-1:0] hold_m = '0;
    snap_t cur_exp;
    snap_t exp_q[$];

    always #5 clk = ~clk;

    xpt_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .ser_load_en(ser_load_en), .ser_in(ser_in),
        .ser_out(ser_out), .par_wr(par_wr), .par_addr(par_addr), .par_data(par_data),
        .update(update), .sel_bus(sel_bus), .en_bus(en_bus)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [CW-1:0] act, input logic [CW-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic snap_t snap_of(input logic [CW-1:0] words);
        snap_t s;
        for (int k = 0; k < N; k++) begin
            s.en[k]        = words[k*W + 4];
            s.sel[k*4 +: 4] = words[k*W +: 4];
        end
        return s;
    endfunction

    // Serial stream order: output 0 first, MSB first within each word
    function automatic logic [CW-1:0] to_stream(input logic [CW-1:0] words);
        logic [CW-1:0] s;
        for (int k = 0; k < N; k++)
            for (int j = 0; j < W; j++)
                s[k*W + j] = words[k*W + W-1-j];
        return s;
    endfunction

    task automatic check_held(input string req);
        chk(en_bus == cur_exp.en, req, "en_bus held", CW'(en_bus), CW'(cur_exp.en));
        chk(sel_bus == cur_exp.sel, req, "sel_bus held", CW'(sel_bus), CW'(cur_exp.sel));
    endtask

    // Monitor: pop the expected snapshot at each update edge, compare after it
    initial begin
        snap_t e;
        forever begin
            @(posedge clk);
            if (update === 1'b1 && rst_n === 1'b1) begin
                e = exp_q.pop_front();
                @(negedge clk);
                chk(en_bus == e.en, "R3", "en_bus after update", CW'(en_bus), CW'(e.en));
                chk(sel_bus == e.sel, "R3", "sel_bus after update", CW'(sel_bus), CW'(e.sel));
                cur_exp = e;
            end
        end
    end

    task automatic do_update();
        @(negedge clk);
        update = 1'b1;
        exp_q.push_back(snap_of(hold_m));
        @(negedge clk);
        update = 1'b0;
        @(negedge clk);
    endtask

    task automatic par_write(input int addr, input logic [W-1:0] data);
        @(negedge clk);
        par_wr = 1'b1; par_addr = addr[3:0]; par_data = data;
        hold_m[addr*W +: W] = data;
        @(negedge clk);
        par_wr = 1'b0;
    endtask

    // Shift a full image in; check ser_out against the previous image (R7)
    task automatic ser_send(input logic [CW-1:0] words, input int inject_t);
        logic [CW-1:0] s_in, s_old;
        s_in  = to_stream(words);
        s_old = to_stream(hold_m);
        for (int t = 0; t < CW; t++) begin
            @(negedge clk);
            chk(ser_out == s_old[t], "R7", "ser_out bit", CW'(ser_out), CW'(s_old[t]));
            ser_load_en = 1'b1;
            ser_in = s_in[t];
            par_wr = (t == inject_t);   // R8: must be ignored
            par_addr = 4'd5;
            par_data = 5'b1_1010;
        end
        @(negedge clk);
        ser_load_en = 1'b0; par_wr = 1'b0;
        hold_m = words;
    endtask

    initial begin
        logic [CW-1:0] img1, img2;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(en_bus == '0, "R1", "en_bus after reset", CW'(en_bus), '0);
        chk(sel_bus == '0, "R1", "sel_bus after reset", CW'(sel_bus), '0);
        cur_exp = snap_of('0);
        do_update();   // R1: update before loading keeps all disabled

        // R2/R4: parallel load, outputs hold until update
        for (int k = 0; k < N; k++) par_write(k, {1'b1, 4'(15 - k)});
        @(negedge clk);
        check_held("R4");
        do_update();   // R2, R3

        // R5: disabled words still carry their index
        par_write(3, 5'b0_0111);
        par_write(9, 5'b0_1100);
        check_held("R2");
        do_update();
        chk(en_bus[3] == 1'b0, "R5", "out3 disabled", CW'(en_bus[3]), '0);
        chk(sel_bus[12 +: 4] == 4'd7, "R5", "out3 index", CW'(sel_bus[12 +: 4]), CW'(7));

        // R6: serial load of a full image
        for (int k = 0; k < N; k++) img1[k*W +: W] = {1'(k % 2), 4'((k * 3) % 16)};
        ser_send(img1, -1);
        check_held("R4");
        do_update();   // R6

        // R7 + R8: second image, parallel strobe mid-shift must be ignored
        for (int k = 0; k < N; k++) img2[k*W +: W] = {1'(k < 8), 4'((k * 7 + 2) % 16)};
        ser_send(img2, 40);
        do_update();   // R8

        // R9: update and parallel write on the same edge
        @(negedge clk);
        update = 1'b1; par_wr = 1'b1; par_addr = 4'd2; par_data = 5'b1_0001;
        exp_q.push_back(snap_of(hold_m));
        hold_m[2*W +: W] = 5'b1_0001;
        @(negedge clk);
        update = 1'b0; par_wr = 1'b0;
        @(negedge clk);
        do_update();   // R9: written word appears now
        chk(sel_bus[8 +: 4] == 4'd1, "R9", "out2 after second update", CW'(sel_bus[8 +: 4]), CW'(1));

        // R1: reset mid-operation disables everything and clears holding
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        hold_m = '0; cur_exp = snap_of('0);
        @(negedge clk);
        chk(en_bus == '0, "R1", "en_bus after second reset", CW'(en_bus), '0);
        do_update();   // R1: holding cleared too

        repeat (2) @(negedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule